// File: doc/BRIEF.md
# Handshaked Shift-Register Byte Mover

This block sits between a host bus and a peripheral controller. It moves packet bytes through an 8-bit shift register and paces them with three active-low handshake lines held in a port-B data register. The host owns the in-progress line (bit 5) and the acknowledge line (bit 4). The block owns the request line (bit 3). A direction input picks the path. In the host-to-device path, shift-register bytes are collected into a 16-entry outbound buffer. In the device-to-host path, bytes come from a 128-entry inbound buffer, which a side port preloads.

Every port-B write is compared with the previous port-B write. While in-progress is low, each change of the {acknowledge, in-progress} pair moves one byte. A rise of in-progress ends the transfer. It raises the shift-register pulse and, if bytes were collected, a packet-complete strobe that carries the byte count. While in-progress stays high and acknowledge toggles, the request line follows acknowledge (sync mode). The block decodes no packet contents.

Top module: `shreg_xfer`

## Requirements
- R1: After reset, portb_q reads 0x38 (host lines high, request deasserted), sr_q is 0, and sr_pulse and pkt_done are low. portb_q echoes the last accepted port-B write on every bit except bit 3, which always shows the request line. With no write and no load, portb_q holds its value.
- R2: With dir_out=1 and bit 5 written low, a write whose bits [5:4] differ from the previous write's bits [5:4] appends sr_q to the outbound buffer at the next index. One cycle later, sr_pulse goes high for one cycle.
- R3: When the outbound buffer already holds 16 bytes, a further moving write drops the byte and gives no sr_pulse.
- R4: A write with bit 5 low whose bits [5:4] equal the previous write's bits moves no byte and gives no sr_pulse.
- R5: With dir_out=0 and unread inbound bytes, each moving write loads the next inbound byte into sr_q and pulses sr_pulse. When no inbound bytes remain, a moving write changes neither sr_q nor sr_pulse.
- R6: The write that consumes the last inbound byte drives portb_q bit 3 high. Bit 3 stays low for the writes that consume the earlier bytes.
- R7: A write with bit 5 high after a write with bit 5 low always pulses sr_pulse. If the outbound buffer holds at least one byte, the same write also raises pkt_done for one cycle, with pkt_len equal to the count, and the count returns to zero.
- R8: A write with bit 5 high, after a write with bit 5 high, that changes bit 4 copies the new bit 4 into portb_q bit 3 and pulses sr_pulse.
- R9: A write with bit 5 high that is not a sync toggle drives portb_q bit 3 low while unread inbound bytes remain.
- R10: A load commit (ld_go) sets the inbound length to ld_len and the read index to zero, and pulses sr_pulse. If port-B bit 5 is high and ld_len is nonzero, the commit drives bit 3 low. A port-B write in the same cycle as a commit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| portb_we | input | 1 | Port-B write strobe |
| portb_wdata | input | 8 | Port-B write value (bit 5 in-progress, bit 4 acknowledge) |
| portb_q | output | 8 | Port-B readback, bit 3 is the request line |
| dir_out | input | 1 | 1 host-to-device, 0 device-to-host |
| sr_we | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Shift-register write value |
| sr_q | output | 8 | Shift-register contents |
| ld_we | input | 1 | Inbound buffer byte write |
| ld_addr | input | 7 | Inbound buffer write address |
| ld_data | input | 8 | Inbound buffer write data |
| ld_go | input | 1 | Commit an inbound packet |
| ld_len | input | 8 | Length of the committed packet |
| ob_rd_addr | input | 4 | Outbound buffer read address |
| ob_rd_data | output | 8 | Outbound buffer byte at ob_rd_addr |
| sr_pulse | output | 1 | Shift-register interrupt pulse |
| pkt_done | output | 1 | Outbound packet complete strobe |
| pkt_len | output | 5 | Byte count presented with pkt_done |

## Verification
Every result is registered. A port-B write, shift-register load or commit that the bench drives on a falling edge is taken at the next rising edge. The request bit, sr_q, sr_pulse, pkt_done and pkt_len are then due in the cycle right after that edge. The bench drops the strobe and samples on the following falling edge, inside that one-cycle pulse window. ob_rd_data is a combinational read of settled buffer contents, so the bench checks it shortly after it sets the address while the bench drives no writes.

// File: rtl/xfer_pkg.sv
// Shared constants and types for the handshaked shift-register byte mover.
// Assumes the port-B bit positions below are fixed by the host software.
package xfer_pkg;
    localparam int BIT_REQ  = 3;
    localparam int BIT_ACK  = 4;
    localparam int BIT_PROG = 5;

    // Kind of handshake event a single port-B write represents.
    typedef enum logic [2:0] {
        EV_NONE = 3'd0,  // in-progress low, pair unchanged
        EV_MOVE = 3'd1,  // in-progress low, pair changed: move a byte
        EV_SYNC = 3'd2,  // in-progress held high, acknowledge toggled
        EV_END  = 3'd3,  // in-progress just rose: transfer ended
        EV_IDLE = 3'd4   // in-progress held high, acknowledge steady
    } hs_ev_t;
endpackage

// File: rtl/hs_decode.sv
// Classifies a port-B write by comparing the new handshake pair with the
// pair of the previous write. Purely combinational; the caller qualifies
// the result with its own write strobe.
module hs_decode
    import xfer_pkg::*;
(
    input  logic [1:0] cur_pair,   // {in-progress, acknowledge} being written
    input  logic [1:0] prev_pair,  // same pair from the previous write
    output hs_ev_t     ev
);
    logic pair_chg;
    logic ack_chg;

    // Change detection on the pair and on acknowledge alone.
    always_comb begin
        pair_chg = (cur_pair != prev_pair);
        ack_chg  = (cur_pair[0] != prev_pair[0]);
    end

    // Event classification; in-progress is active low.
    always_comb begin
        if (!cur_pair[1])
            ev = pair_chg ? EV_MOVE : EV_NONE;
        else if (prev_pair[1] && ack_chg)
            ev = EV_SYNC;
        else if (!prev_pair[1])
            ev = EV_END;
        else
            ev = EV_IDLE;
    end
endmodule

// File: rtl/ob_buf.sv
// Outbound (host-to-device) byte collector. Appends on push while not
// full, clears its count on clear. Assumes push and clear never coincide.
module ob_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          clear,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] cnt,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];

    // Fill level flag.
    always_comb full = (cnt == CW'(DEPTH));

    // Count tracking: grow on accepted push, drop to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + 1'b1;
    end

    // Storage write at the current count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !full) begin
            mem[cnt[AW-1:0]] <= push_data;
        end
    end

    // Readback port.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/ib_buf.sv
// Inbound (device-to-host) packet store. A side port writes bytes and a
// commit sets the length and rewinds the read index. Assumes a commit and
// a pop never happen in the same cycle (the top gives commit priority).
module ib_buf #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic [CW-1:0] commit_len,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          pending,
    output logic          last
);
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] size_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] len_clamped;

    // Clamp an oversized commit to the storage depth.
    always_comb len_clamped = (commit_len > CW'(DEPTH)) ? CW'(DEPTH) : commit_len;

    // Side-port byte writes.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Length and read index: commit rewinds, pop advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            idx_q  <= '0;
        end else if (commit) begin
            size_q <= len_clamped;
            idx_q  <= '0;
        end else if (pop && pending) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Head byte and remaining-data status.
    always_comb begin
        pending = (idx_q < size_q);
        last    = ((idx_q + 1'b1) == size_q);
        head    = mem[idx_q[AW-1:0]];
    end
endmodule

// File: rtl/shreg_xfer.sv
// Top of the handshaked shift-register byte mover. Every port-B write is
// classified against the previous write; bytes move between the shift
// register and the outbound or inbound buffer. The request line, the
// shift-register pulse and the packet-complete strobe are registered.
// Assumes the host writes port B as a whole byte; bit 3 of the write is
// ignored because the block owns the request line.
module shreg_xfer
    import xfer_pkg::*;
#(
    parameter int OB_DEPTH = 16,
    parameter int IB_DEPTH = 128,
    localparam int OB_AW   = $clog2(OB_DEPTH),
    localparam int OB_CW   = $clog2(OB_DEPTH + 1),
    localparam int IB_AW   = $clog2(IB_DEPTH),
    localparam int IB_CW   = $clog2(IB_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             portb_we,
    input  logic [7:0]       portb_wdata,
    output logic [7:0]       portb_q,
    input  logic             dir_out,
    input  logic             sr_we,
    input  logic [7:0]       sr_wdata,
    output logic [7:0]       sr_q,
    input  logic             ld_we,
    input  logic [IB_AW-1:0] ld_addr,
    input  logic [7:0]       ld_data,
    input  logic             ld_go,
    input  logic [IB_CW-1:0] ld_len,
    input  logic [OB_AW-1:0] ob_rd_addr,
    output logic [7:0]       ob_rd_data,
    output logic             sr_pulse,
    output logic             pkt_done,
    output logic [OB_CW-1:0] pkt_len
);
    localparam logic [7:0] PORTB_RST = 8'h30;

    logic [7:0]       b_q;
    logic             req_q;
    logic [7:0]       sr_r;
    logic             pulse_q;
    logic             done_q;
    logic [OB_CW-1:0] len_q;

    hs_ev_t           ev;
    logic             wr_b;
    logic             ob_push;
    logic             ob_clear;
    logic [OB_CW-1:0] ob_cnt;
    logic             ob_full;
    logic             ib_pop;
    logic [7:0]       ib_head;
    logic             ib_pending;
    logic             ib_last;

    hs_decode u_dec (
        .cur_pair  ({portb_wdata[BIT_PROG], portb_wdata[BIT_ACK]}),
        .prev_pair ({b_q[BIT_PROG], b_q[BIT_ACK]}),
        .ev        (ev)
    );

    ob_buf #(.DEPTH(OB_DEPTH), .DW(8)) u_ob (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ob_push),
        .push_data (sr_r),
        .clear     (ob_clear),
        .rd_addr   (ob_rd_addr),
        .rd_data   (ob_rd_data),
        .cnt       (ob_cnt),
        .full      (ob_full)
    );

    ib_buf #(.DEPTH(IB_DEPTH), .DW(8)) u_ib (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ld_we),
        .wr_addr    (ld_addr),
        .wr_data    (ld_data),
        .commit     (ld_go),
        .commit_len (ld_len),
        .pop        (ib_pop),
        .head       (ib_head),
        .pending    (ib_pending),
        .last       (ib_last)
    );

    // Qualified events: a commit in the same cycle masks the port-B write.
    always_comb begin
        wr_b     = portb_we && !ld_go;
        ob_push  = wr_b && (ev == EV_MOVE) && dir_out && !ob_full;
        ib_pop   = wr_b && (ev == EV_MOVE) && !dir_out && ib_pending;
        ob_clear = wr_b && (ev == EV_END);
    end

    // Port-B copy kept for readback and for the next comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_q <= PORTB_RST;
        else if (wr_b) b_q <= portb_wdata;
    end

    // Request line (active low) driven from buffer state and sync mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b1;
        end else if (ld_go) begin
            if (b_q[BIT_PROG] && (ld_len != '0)) req_q <= 1'b0;
        end else if (wr_b) begin
            unique case (ev)
                EV_MOVE:          if (ib_pop && ib_last) req_q <= 1'b1;
                EV_SYNC:          req_q <= portb_wdata[BIT_ACK];
                EV_END, EV_IDLE:  if (ib_pending) req_q <= 1'b0;
                default:          req_q <= req_q;
            endcase
        end
    end

    // Shift register: inbound byte load wins over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr_r <= '0;
        else if (ib_pop) sr_r <= ib_head;
        else if (sr_we)  sr_r <= sr_wdata;
    end

    // One-cycle shift-register pulse and packet-complete strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            done_q  <= 1'b0;
            len_q   <= '0;
        end else begin
            pulse_q <= ld_go || ob_push || ib_pop
                       || (wr_b && ((ev == EV_SYNC) || (ev == EV_END)));
            done_q  <= ob_clear && (ob_cnt != '0);
            len_q   <= (ob_clear && (ob_cnt != '0)) ? ob_cnt : '0;
        end
    end

    // Output mapping.
    always_comb begin
        portb_q          = b_q;
        portb_q[BIT_REQ] = req_q;
        sr_q             = sr_r;
        sr_pulse         = pulse_q;
        pkt_done         = done_q;
        pkt_len          = len_q;
    end
endmodule

// File: rtl/shreg_xfer_chk.sv
// Property checker for shreg_xfer, attached by the bind below. It observes
// ports plus the outbound count; it drives nothing.
module shreg_xfer_chk #(
    parameter int OB_DEPTH = 16,
    localparam int OB_CW   = $clog2(OB_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             portb_we,
    input logic [7:0]       portb_wdata,
    input logic [7:0]       portb_q,
    input logic             ld_go,
    input logic             dir_out,
    input logic             sr_pulse,
    input logic             pkt_done,
    input logic [OB_CW-1:0] pkt_len,
    input logic [OB_CW-1:0] ob_cnt
);
    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_pulse |-> $past(portb_we || ld_go)); // R2

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (portb_we && !ld_go && dir_out && !portb_wdata[5]
         && (ob_cnt == OB_CW'(OB_DEPTH))) |=> !sr_pulse); // R3

    AST_DONE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> sr_pulse); // R7

    AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> ((pkt_len != '0) && (pkt_len <= OB_CW'(OB_DEPTH)))); // R7

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!portb_we && !ld_go) |=> $stable(portb_q)); // R1

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> sr_pulse); // R10

    AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (portb_we && !ld_go && portb_wdata[5] && portb_q[5]
         && (portb_wdata[4] != portb_q[4]))
        |=> (portb_q[3] == $past(portb_wdata[4]))); // R8
endmodule

bind shreg_xfer shreg_xfer_chk #(.OB_DEPTH(OB_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .portb_we    (portb_we),
    .portb_wdata (portb_wdata),
    .portb_q     (portb_q),
    .ld_go       (ld_go),
    .dir_out     (dir_out),
    .sr_pulse    (sr_pulse),
    .pkt_done    (pkt_done),
    .pkt_len     (pkt_len),
    .ob_cnt      (ob_cnt)
);

// File: tb/shreg_xfer_test.sv
// Sweeping bench for shreg_xfer: outbound packets of 1..18 bytes, inbound
// packets of 1..6 bytes, sync toggles, idle requests and commit collisions.
module shreg_xfer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       portb_we = 1'b0;
    logic [7:0] portb_wdata = '0;
    logic [7:0] portb_q;
    logic       dir_out = 1'b1;
    logic       sr_we = 1'b0;
    logic [7:0] sr_wdata = '0;
    logic [7:0] sr_q;
    logic       ld_we = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       ld_go = 1'b0;
    logic [7:0] ld_len = '0;
    logic [3:0] ob_rd_addr = '0;
    logic [7:0] ob_rd_data;
    logic       sr_pulse;
    logic       pkt_done;
    logic [4:0] pkt_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] s_b, s_sr;
    logic       s_p, s_d;
    logic [4:0] s_l;

    shreg_xfer uut (
        .clk(clk), .rst_n(rst_n), .portb_we(portb_we), .portb_wdata(portb_wdata),
        .portb_q(portb_q), .dir_out(dir_out), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .sr_q(sr_q), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .ld_go(ld_go), .ld_len(ld_len), .ob_rd_addr(ob_rd_addr),
        .ob_rd_data(ob_rd_data), .sr_pulse(sr_pulse), .pkt_done(pkt_done),
        .pkt_len(pkt_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(int n, int k);
        return 8'((n * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic grab();
        s_b = portb_q; s_sr = sr_q; s_p = sr_pulse; s_d = pkt_done; s_l = pkt_len;
    endtask

    task automatic pbw(logic [7:0] v);
        @(negedge clk); portb_we = 1'b1; portb_wdata = v;
        @(negedge clk); portb_we = 1'b0; grab();
    endtask

    task automatic srw(logic [7:0] v);
        @(negedge clk); sr_we = 1'b1; sr_wdata = v;
        @(negedge clk); sr_we = 1'b0;
    endtask

    task automatic load(int n, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ld_we = 1'b1; ld_addr = 7'(i); ld_data = pat(seed, i);
        end
        @(negedge clk); ld_we = 1'b0; ld_go = 1'b1; ld_len = 8'(n);
        @(negedge clk); ld_go = 1'b0; grab();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        grab();
        chk("R1 reset portb", s_b, 8'h38);
        chk("R1 reset sr", s_sr, 0);
        chk("R1 reset pulse", s_p, 0);
        chk("R1 reset done", s_d, 0);

        // Outbound sweep: R2, R3, R4, R7
        dir_out = 1'b1;
        for (int n = 1; n <= 18; n++) begin
            logic [7:0] v;
            for (int k = 0; k < n; k++) begin
                srw(pat(n, k));
                v = (k % 2 == 0) ? 8'h10 : 8'h00;
                pbw(v);
                chk(k < 16 ? "R2 move pulse" : "R3 full drop", s_p, k < 16 ? 1 : 0);
                chk("R1 echo", s_b[5:4], v[5:4]);
                if (n == 5 && k == 2) begin
                    pbw(v);
                    chk("R4 no change no pulse", s_p, 0);
                end
            end
            pbw(8'h30);
            chk("R7 end pulse", s_p, 1);
            chk("R7 done", s_d, 1);
            chk("R7 len", s_l, n < 16 ? n : 16);
            for (int i = 0; i < (n < 16 ? n : 16); i++) begin
                ob_rd_addr = 4'(i); #1;
                chk("R2 stored byte", ob_rd_data, pat(n, i));
            end
            pbw(8'h30);
            chk("R7 idle no pulse", s_p, 0);
            chk("R7 idle no done", s_d, 0);
        end

        // Inbound sweep: R5, R6, R10
        dir_out = 1'b0;
        for (int n = 1; n <= 6; n++) begin
            load(n, n + 40);
            chk("R10 load pulse", s_p, 1);
            chk("R10 req low", s_b[3], 0);
            for (int k = 0; k <= n; k++) begin
                logic [7:0] prev_sr;
                prev_sr = s_sr;
                pbw((k % 2 == 0) ? 8'h10 : 8'h00);
                if (k < n) begin
                    chk("R5 read pulse", s_p, 1);
                    chk("R5 read byte", s_sr, pat(n + 40, k));
                    chk("R6 req", s_b[3], (k == n - 1) ? 1 : 0);
                end else begin
                    chk("R5 exhausted no pulse", s_p, 0);
                    chk("R5 exhausted sr held", s_sr, prev_sr);
                end
            end
            pbw(8'h30);
            chk("R7 end pulse input", s_p, 1);
            chk("R7 no done input", s_d, 0);
            chk("R6 req stays high", s_b[3], 1);
        end

        // Sync mode: R8
        pbw(8'h20);
        chk("R8 pulse", s_p, 1);
        chk("R8 req follows low", s_b[3], 0);
        pbw(8'h30);
        chk("R8 req follows high", s_b[3], 1);
        pbw(8'h30);
        chk("R8 steady no pulse", s_p, 0);

        // Load while in-progress low, then end: R9, R10
        pbw(8'h10);
        chk("R5 empty no pulse", s_p, 0);
        load(2, 90);
        chk("R10 load pulse low tip", s_p, 1);
        chk("R10 req untouched tip low", s_b[3], 1);
        pbw(8'h30);
        chk("R9 end pulse", s_p, 1);
        chk("R9 req low pending", s_b[3], 0);
        pbw(8'h37);
        chk("R9 idle req low", s_b[3], 0);
        chk("R1 host bit3 ignored", s_b, 8'h37 & 8'hF7);

        // Commit collides with a port-B write: R10
        @(negedge clk); ld_go = 1'b1; ld_len = 8'd1; portb_we = 1'b1; portb_wdata = 8'h20;
        @(negedge clk); ld_go = 1'b0; portb_we = 1'b0; grab();
        chk("R10 collide write ignored", s_b[5:4], 2'b11);
        chk("R10 collide pulse", s_p, 1);
        chk("R10 collide req", s_b[3], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule